// File: doc/BRIEF.md
# Display PHY Power-Up Sequencer

This block brings the analog macro of a serial display transmitter from fully powered down to operational. It owns seven active-high power-down controls: port, PLL, bandgap, VCO, PLL capacitor, deep power-down and pad calibration. After a start request it moves through five fixed steps and releases one group of controls at each step. Between the steps it waits a programmed number of microseconds. The microseconds are counted from a one-cycle strobe that pulses once per microsecond.

The release of deep power-down is a handshake with the power-management unit. The block raises a sample-enable output and then drops its deep power-down control. It reads the unit's status bit once per poll interval and continues only after the bit reads clear. If the status has not cleared within the timeout, the block enters a sticky error state and returns every control to the fully powered-down pattern. Once the sequence has finished, the block stays up, and further start requests leave it unchanged. All delays are parameters, so a testbench can shorten them.

Top module: `phy_pwrup_seq`

## Requirements
- R1: After reset all seven power-down controls are high, and busy, done, err and pmu_sample_en are low.
- R2: A start seen while the block is off or in error gives one cycle with all seven controls high, pmu_sample_en high, busy high and err low. In the next cycle only pdn_deep is low.
- R3: While it waits for the power-management unit, the block samples pmu_dpd_stat on every POLL_US-th tick counted from the deep release. The first such sample that reads 0 lowers pmu_sample_en on the same clock edge. Until then pmu_sample_en stays high.
- R4: If pmu_dpd_stat still reads 1 at the sample on tick TMO_US, err rises on that edge. At the same edge all seven controls go high, and busy and pmu_sample_en go low.
- R5: pdn_bg falls on the edge that samples the T_BG_US-th tick after the handshake ends, and not earlier.
- R6: pdn_pll, pdn_vco and pdn_cap fall together on the edge that samples the T_PLL_US-th tick after the bandgap release.
- R7: pdn_port falls on the edge that samples the T_PORT_US-th tick after the PLL group release. On that edge done rises and busy falls.
- R8: pdn_cal stays high at all times.
- R9: err stays high, with all controls high, until the next start.
- R10: A start while done is high has no effect: done stays high, busy stays low and the controls do not change.
- R11: A start held or repeated while busy is high does not restart or disturb the sequence.
- R12: The controls are released only in the order deep, bandgap, PLL group, port. At most one of busy, done and err is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Power-up request |
| us_tick | input | 1 | One-cycle strobe once per microsecond |
| pmu_dpd_stat | input | 1 | Power-management status, 1 while the IO is still in deep power-down |
| pdn_port | output | 1 | Port power-down |
| pdn_pll | output | 1 | PLL power-down |
| pdn_bg | output | 1 | Bandgap power-down |
| pdn_vco | output | 1 | VCO power-down |
| pdn_cap | output | 1 | PLL capacitor power-down |
| pdn_deep | output | 1 | Deep power-down request to the power-management unit |
| pdn_cal | output | 1 | Pad calibration power-down |
| pmu_sample_en | output | 1 | Sample-enable to the power-management unit |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Macro powered up |
| err | output | 1 | Handshake timeout, sticky until the next start |

## Verification
The handshake properties assume that pmu_dpd_stat and us_tick are stable around each clock edge and that us_tick is a single-cycle pulse. They also assume that the status bit only matters while the handshake is running. The bench drives both inputs on the falling edge from its own model of the power-management unit. That model clears the status a chosen number of ticks after the deep release. The bench sweeps that number from immediate release to past the timeout, with ticks every one, two and three cycles. The start input is kept to pulses, except in one run that holds it high on purpose.

// File: rtl/phy_pwrup_pkg.sv
package phy_pwrup_pkg;

   typedef enum logic [2:0] {
      S_OFF  = 3'd0,
      S_ARM  = 3'd1,
      S_DPD  = 3'd2,
      S_BG   = 3'd3,
      S_PLL  = 3'd4,
      S_PORT = 3'd5,
      S_ON   = 3'd6,
      S_ERR  = 3'd7
   } seq_state_e;

   localparam int NUM_PDN = 7;

   // control indices inside the decoded vector
   localparam int IX_CAL  = 0;
   localparam int IX_DEEP = 1;
   localparam int IX_CAP  = 2;
   localparam int IX_VCO  = 3;
   localparam int IX_BG   = 4;
   localparam int IX_PLL  = 5;
   localparam int IX_PORT = 6;

   // step level reached by each state (1 = everything powered down)
   function automatic int unsigned stage_of(seq_state_e s);
      case (s)
         S_DPD, S_BG: return 2;
         S_PLL:       return 3;
         S_PORT:      return 4;
         S_ON:        return 5;
         default:     return 1;
      endcase
   endfunction

   // first step level at which a control is released; 6 means never
   function automatic int unsigned release_step(int idx);
      case (idx)
         IX_DEEP:               return 2;
         IX_BG:                 return 3;
         IX_PLL, IX_VCO, IX_CAP: return 4;
         IX_PORT:               return 5;
         default:               return 6;
      endcase
   endfunction

endpackage

// File: rtl/phy_pwrup_tick_timer.sv
module phy_pwrup_tick_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic         tick,
   input  logic [W-1:0] limit,
   output logic         hit
);

   logic [W-1:0] cnt_q;

   assign hit = en && tick && (cnt_q == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr || hit)
         cnt_q <= '0;
      else if (en && tick)
         cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/phy_pwrup_decode.sv
module phy_pwrup_decode
   import phy_pwrup_pkg::*;
#(
   parameter int N = NUM_PDN
) (
   input  seq_state_e   state,
   output logic [N-1:0] pdn
);

   for (genvar i = 0; i < N; i++) begin : g_pdn
      assign pdn[i] = (stage_of(state) < release_step(i));
   end

endmodule

// File: rtl/phy_pwrup_seq.sv
module phy_pwrup_seq
   import phy_pwrup_pkg::*;
#(
   parameter int T_BG_US   = 15,
   parameter int T_PLL_US  = 25,
   parameter int T_PORT_US = 225,
   parameter int POLL_US   = 20,
   parameter int TMO_US    = 10000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic us_tick,
   input  logic pmu_dpd_stat,
   output logic pdn_port,
   output logic pdn_pll,
   output logic pdn_bg,
   output logic pdn_vco,
   output logic pdn_cap,
   output logic pdn_deep,
   output logic pdn_cal,
   output logic pmu_sample_en,
   output logic busy,
   output logic done,
   output logic err
);

   localparam int NPOLL   = TMO_US / POLL_US;
   localparam int DLY_MAX = (T_PORT_US > T_PLL_US) ?
                            ((T_PORT_US > T_BG_US) ? T_PORT_US : T_BG_US) :
                            ((T_PLL_US > T_BG_US) ? T_PLL_US : T_BG_US);
   localparam int DW = $clog2(DLY_MAX + 1);
   localparam int PW = $clog2(POLL_US + 1);
   localparam int NW = $clog2(NPOLL + 1);

   if (T_BG_US < 1 || T_PLL_US < 1 || T_PORT_US < 1) begin : g_bad_dly
      $error("step delays must be at least one microsecond");
   end
   if (POLL_US < 1 || TMO_US < POLL_US) begin : g_bad_poll
      $error("poll interval must be positive and not exceed the timeout");
   end
   if ((TMO_US % POLL_US) != 0) begin : g_bad_tmo
      $error("timeout must be a whole number of poll intervals");
   end

   seq_state_e state_q, state_d;
   logic       in_dpd, in_wait, moving;
   logic       dly_hit, poll_hit, poll_last;
   logic [DW-1:0] dly_limit;
   logic [NUM_PDN-1:0] pdn_vec;

   assign in_dpd  = (state_q == S_DPD);
   assign in_wait = (state_q == S_BG) || (state_q == S_PLL) || (state_q == S_PORT);
   assign moving  = (state_d != state_q);

   always_comb begin
      case (state_q)
         S_PLL:   dly_limit = DW'(T_PLL_US);
         S_PORT:  dly_limit = DW'(T_PORT_US);
         default: dly_limit = DW'(T_BG_US);
      endcase
   end

   phy_pwrup_tick_timer #(.W(DW)) u_step_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_wait),
      .clr   (moving),
      .tick  (us_tick),
      .limit (dly_limit),
      .hit   (dly_hit)
   );

   phy_pwrup_tick_timer #(.W(PW)) u_poll_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_dpd),
      .clr   (moving),
      .tick  (us_tick),
      .limit (PW'(POLL_US)),
      .hit   (poll_hit)
   );

   phy_pwrup_tick_timer #(.W(NW)) u_poll_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (in_dpd),
      .clr   (moving),
      .tick  (poll_hit),
      .limit (NW'(NPOLL)),
      .hit   (poll_last)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_OFF, S_ERR: if (start) state_d = S_ARM;
         S_ARM:        state_d = S_DPD;
         S_DPD: begin
            if (poll_hit) begin
               if (!pmu_dpd_stat)  state_d = S_BG;
               else if (poll_last) state_d = S_ERR;
            end
         end
         S_BG:    if (dly_hit) state_d = S_PLL;
         S_PLL:   if (dly_hit) state_d = S_PORT;
         S_PORT:  if (dly_hit) state_d = S_ON;
         S_ON:    state_d = S_ON;
         default: state_d = S_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= S_OFF;
      else        state_q <= state_d;
   end

   phy_pwrup_decode #(.N(NUM_PDN)) u_decode (
      .state (state_q),
      .pdn   (pdn_vec)
   );

   assign pdn_port = pdn_vec[IX_PORT];
   assign pdn_pll  = pdn_vec[IX_PLL];
   assign pdn_bg   = pdn_vec[IX_BG];
   assign pdn_vco  = pdn_vec[IX_VCO];
   assign pdn_cap  = pdn_vec[IX_CAP];
   assign pdn_deep = pdn_vec[IX_DEEP];
   assign pdn_cal  = pdn_vec[IX_CAL];

   assign pmu_sample_en = (state_q == S_ARM) || in_dpd;
   assign busy          = (state_q == S_ARM) || in_dpd || in_wait;
   assign done          = (state_q == S_ON);
   assign err           = (state_q == S_ERR);

endmodule

// File: rtl/phy_pwrup_seq_chk.sv
module phy_pwrup_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic us_tick,
   input logic pmu_dpd_stat,
   input logic pdn_port,
   input logic pdn_pll,
   input logic pdn_bg,
   input logic pdn_vco,
   input logic pdn_cap,
   input logic pdn_deep,
   input logic pdn_cal,
   input logic pmu_sample_en,
   input logic busy,
   input logic done,
   input logic err
);

   a_r8_cal_held: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_cal);

   a_r12_bg_after_deep: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_bg |-> !pdn_deep);

   a_r12_pll_after_bg: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_pll |-> !pdn_bg);

   a_r12_port_after_pll: assert property (@(posedge clk) disable iff (!rst_n)
      !pdn_port |-> !pdn_pll);

   a_r6_group_together: assert property (@(posedge clk) disable iff (!rst_n)
      (pdn_pll == pdn_vco) && (pdn_vco == pdn_cap));

   a_r12_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy, done, err}));

   a_r4_err_safe: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (pdn_port && pdn_pll && pdn_bg && pdn_vco && pdn_cap && pdn_deep
               && !busy && !pmu_sample_en));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !start) |=> err);

   a_r10_on_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && !busy));

   a_r7_done_port: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!pdn_port && !busy));

   a_r3_sample_drop: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(pmu_sample_en) && !err) |-> ($past(us_tick) && !$past(pmu_dpd_stat)));

   a_r2_arm_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (pmu_sample_en && pdn_deep && !err));

endmodule

bind phy_pwrup_seq phy_pwrup_seq_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .us_tick       (us_tick),
   .pmu_dpd_stat  (pmu_dpd_stat),
   .pdn_port      (pdn_port),
   .pdn_pll       (pdn_pll),
   .pdn_bg        (pdn_bg),
   .pdn_vco       (pdn_vco),
   .pdn_cap       (pdn_cap),
   .pdn_deep      (pdn_deep),
   .pdn_cal       (pdn_cal),
   .pmu_sample_en (pmu_sample_en),
   .busy          (busy),
   .done          (done),
   .err           (err)
);

// File: tb/phy_pwrup_seq_tb.sv
module phy_pwrup_seq_tb;

   localparam int T_BG   = 3;
   localparam int T_PLL  = 5;
   localparam int T_PORT = 7;
   localparam int POLL   = 4;
   localparam int TMO    = 16;

   // vector order {port, pll, bg, vco, cap, deep, cal}
   localparam logic [6:0] V_ALL  = 7'b1111111;
   localparam logic [6:0] V_DEEP = 7'b1111101;
   localparam logic [6:0] V_BG   = 7'b1101101;
   localparam logic [6:0] V_PLL  = 7'b1000001;
   localparam logic [6:0] V_PORT = 7'b0000001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic us_tick = 1'b0;
   logic pmu_dpd_stat = 1'b1;
   logic pdn_port, pdn_pll, pdn_bg, pdn_vco, pdn_cap, pdn_deep, pdn_cal;
   logic pmu_sample_en, busy, done, err;
   logic [6:0] vec;

   int n_chk = 0;
   int n_fail = 0;
   int tick_ctr = 0;
   int tick_div = 1;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   phy_pwrup_seq #(
      .T_BG_US   (T_BG),
      .T_PLL_US  (T_PLL),
      .T_PORT_US (T_PORT),
      .POLL_US   (POLL),
      .TMO_US    (TMO)
   ) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (start),
      .us_tick       (us_tick),
      .pmu_dpd_stat  (pmu_dpd_stat),
      .pdn_port      (pdn_port),
      .pdn_pll       (pdn_pll),
      .pdn_bg        (pdn_bg),
      .pdn_vco       (pdn_vco),
      .pdn_cap       (pdn_cap),
      .pdn_deep      (pdn_deep),
      .pdn_cal       (pdn_cal),
      .pmu_sample_en (pmu_sample_en),
      .busy          (busy),
      .done          (done),
      .err           (err)
   );

   assign vec = {pdn_port, pdn_pll, pdn_bg, pdn_vco, pdn_cap, pdn_deep, pdn_cal};

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive_tick();
      tick_ctr++;
      us_tick = ((tick_ctr % tick_div) == 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      us_tick = 1'b0;
      pmu_dpd_stat = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(vec == V_ALL, "R1", "controls after reset", vec, V_ALL);
      chk({busy, done, err, pmu_sample_en} == 4'b0, "R1", "flags after reset",
          {busy, done, err, pmu_sample_en}, 0);
   endtask

   task automatic run(input int div, input int k, input bit hold, output bit ended_err);
      int cnt;
      int phase;
      int guard;
      bit tp;
      bit pp;
      tick_div = div;
      tick_ctr = 0;
      @(negedge clk);
      start = 1'b1;
      pmu_dpd_stat = (k > 0);
      drive_tick();
      @(negedge clk);
      chk(vec == V_ALL && pmu_sample_en && busy && !err && !done, "R2",
          "arm cycle vector", vec, V_ALL);
      if (!hold) start = 1'b0;
      drive_tick();
      phase = 0;
      cnt = 0;
      guard = 0;
      while (phase < 5 && guard < 5000) begin
         @(negedge clk);
         guard++;
         tp = us_tick;
         pp = pmu_dpd_stat;
         chk(pdn_cal == 1'b1, "R8", "pad calibration held", pdn_cal, 1);
         case (phase)
            0: begin
               chk(vec == V_DEEP && pmu_sample_en && busy, "R2", "deep release only",
                   vec, V_DEEP);
               phase = 1;
               cnt = 0;
            end
            1: begin
               if (tp) cnt++;
               if (tp && (cnt % POLL) == 0) begin
                  if (!pp) begin
                     chk(!pmu_sample_en && vec == V_DEEP && busy, "R3",
                         "handshake end at poll", pmu_sample_en, 0);
                     phase = 2;
                     cnt = 0;
                  end else if (cnt == TMO) begin
                     chk(err && vec == V_ALL && !busy && !pmu_sample_en, "R4",
                         "timeout state", vec, V_ALL);
                     phase = 6;
                  end else begin
                     chk(pmu_sample_en && !err && vec == V_DEEP, "R3",
                         "still polling", pmu_sample_en, 1);
                  end
               end else begin
                  chk(pmu_sample_en && vec == V_DEEP, "R3", "between polls",
                      pmu_sample_en, 1);
               end
            end
            2: begin
               if (tp) cnt++;
               if (cnt == T_BG) begin
                  chk(vec == V_BG, "R5", "bandgap release", vec, V_BG);
                  phase = 3;
                  cnt = 0;
               end else if (tp) begin
                  chk(vec == V_DEEP, "R5", "bandgap early", vec, V_DEEP);
               end
            end
            3: begin
               if (tp) cnt++;
               if (cnt == T_PLL) begin
                  chk(vec == V_PLL, "R6", "PLL group release", vec, V_PLL);
                  phase = 4;
                  cnt = 0;
               end else if (tp) begin
                  chk(vec == V_BG, "R6", "PLL group early", vec, V_BG);
               end
            end
            4: begin
               if (tp) cnt++;
               if (cnt == T_PORT) begin
                  chk(vec == V_PORT && done && !busy, "R7", "port release and done",
                      vec, V_PORT);
                  phase = 5;
               end else if (tp) begin
                  chk(vec == V_PLL && busy && !done, "R7", "port early", vec, V_PLL);
               end
            end
            default: ;
         endcase
         if (hold && phase < 5) chk(busy, "R11", "held start keeps sequence", busy, 1);
         pmu_dpd_stat = (phase <= 1) ? (cnt < k) : 1'b0;
         drive_tick();
      end
      chk(guard < 5000, "R7", "sequence finished", guard, 0);
      ended_err = (phase == 6);
      start = 1'b0;
   endtask

   task automatic after_err();
      pmu_dpd_stat = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(err && vec == V_ALL && !busy, "R9", "error sticky", err, 1);
         drive_tick();
      end
   endtask

   task automatic after_done();
      @(negedge clk);
      start = 1'b1;
      drive_tick();
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 4; i++) begin
         chk(done && !busy && vec == V_PORT, "R10", "start while up", vec, V_PORT);
         @(negedge clk);
         drive_tick();
      end
   endtask

   initial begin
      bit prev_err;
      bit e;
      do_reset();
      prev_err = 1'b0;
      for (int div = 1; div <= 3; div++) begin
         for (int k = 0; k <= TMO + 2; k++) begin
            if (!prev_err) do_reset();
            run(div, k, (div == 2 && k == 5), e);
            if (e) after_err();
            else   after_done();
            prev_err = e;
         end
      end
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule